// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block derives up to three output clocks from a reference clock. Each output has its own divider, programmed with an integer N from 1 to 32. For each output, a static flag chooses between two source clocks. The bypass path divides the reference clock directly. The synthesized path divides a clock supplied from outside the block. That external clock has already been multiplied and pre-divided, so the output frequency is f_ref·m/(n·N).

On the bypass path an output can also divide by N/2, for example 1.5 when N is 3. This half-step mode is allowed only when two conditions hold: the source-select flag names the internal fixed-frequency oscillator (nominally 100 MHz), and that output is bypassed. A request made under any other condition, or with N equal to 1, is ignored. In that case the output uses plain integer division and the configuration-valid flag drops.

Each divider counts its source's half-cycles modulo a period P:
- P is 2N in integer mode and N in half-step mode.
- A rising-edge register sets the output level for the high phase of each source cycle.
- A falling-edge register sets the level for the low phase.
- The output is the XOR of the two registers, so only one register changes at each edge.

Each divider runs a two-state machine:
- S_HOLD is entered at every source rising edge where reset is high. In this state the counters are cleared and the output is driven low.
- S_RUN is entered from S_HOLD at the first rising edge with reset low. That edge loads the configuration and starts period position 0. S_RUN stays in S_RUN while reset is low.
- Inside S_RUN, a new configuration is loaded only at a clean period boundary.

Top module: `halfstep_clk_div`

## Requirements
- R1: With bypass set and half-step inactive, an output's period is 2N reference half-cycles. N is the 5-bit divider code plus 1, so code 0 gives N=1 and code 31 gives N=32.
- R2: With use_osc=1, bypass=1, half_en=1 and N≥2, an output's period is N reference half-cycles.
- R3: In every mode the output is high for the first ceil(P/2) source half-cycles of its period of P half-cycles and low for the rest. Integer mode therefore gives a 50% duty cycle for every N, odd N included.
- R4: A half-step request is ignored, and the output uses period 2N, when N=1, when use_osc=0, or when that output's bypass flag is 0. cfg_valid is then 0 from the following reference rising edge.
- R5: cfg_valid is 1 one reference rising edge after an input configuration containing no ignored half-step request.
- R6: With bypass=0, an output is the clk_syn clock divided by N: its period is 2N clk_syn half-cycles.
- R7: While rst is high, every output and cfg_valid are low. At the first source rising edge with rst low, the output goes high (period position 0).
- R8: A change of divider code or mode does not shorten or stretch the period in progress. The new period applies from the next period start that coincides with a source rising edge.
- R9: Each output's period depends only on its own divider code, half-step flag and bypass flag, plus the shared use_osc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| clk_syn | input | 1 | Externally synthesized clock for non-bypass outputs |
| rst | input | 1 | Synchronous reset, active high, seen in each source domain |
| use_osc | input | 1 | 1: internal fixed oscillator is the selected source |
| bypass | input | NUM_OUT | Per output: 1 divides clk_ref, 0 divides clk_syn (static outside reset) |
| half_en | input | NUM_OUT | Per output half-step request |
| div_code | input | NUM_OUT x DIV_W | Per output divider code, N = code + 1 |
| clk_out | output | NUM_OUT | Divided clocks |
| cfg_valid | output | 1 | 0 while any half-step request is being ignored |

## Verification
Each divider's internal state can go wrong in two places, the half-cycle counter or the latched period. Either error shows at the ports within one output period, as a wrong spacing between rising edges or a wrong high time. The bench therefore measures both quantities, in source half-cycles, for every N in both modes. A boundary load that happens at the wrong time stretches or truncates the single period during which the code changes. The bench measures that one period across a mid-period code change. A wrong gating decision shows one reference cycle later on cfg_valid, together with an integer period where a half-step period was requested.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

    // Width of one divider code; N = code + 1
    parameter int unsigned HD_DIV_W = 5;

    typedef enum logic {
        S_HOLD = 1'b0,
        S_RUN  = 1'b1
    } hdiv_state_e;

endpackage

// File: rtl/hdiv_cfg.sv
module hdiv_cfg #(
    parameter int unsigned DIV_W = hdiv_pkg::HD_DIV_W,
    localparam int unsigned CW   = DIV_W + 2
) (
    input  logic             use_osc,
    input  logic             byp,
    input  logic             half_req,
    input  logic [DIV_W-1:0] div_code,
    output logic [CW-1:0]    per_hc,
    output logic             req_bad
);

    logic [CW-1:0] n_val;
    logic          half_ok;

    always_comb begin
        n_val   = CW'(div_code) + CW'(1);
        half_ok = use_osc && byp && (div_code != '0);
        per_hc  = (half_req && half_ok) ? n_val : (n_val << 1);
        req_bad = half_req && !half_ok;
    end

endmodule

// File: rtl/hdiv_core.sv
module hdiv_core #(
    parameter int unsigned DIV_W = hdiv_pkg::HD_DIV_W,
    localparam int unsigned CW   = DIV_W + 2
) (
    input  logic          src_clk,
    input  logic          rst,
    input  logic [CW-1:0] per_new,
    output logic          clk_o
);
    import hdiv_pkg::*;

    hdiv_state_e   state_q;
    logic [CW-1:0] per_q, cnt_q;
    logic [CW-1:0] use_per, base, pos0, pos1, hi_len, cnt_adv, base_p1, base_p2;
    logic          at_bound;
    logic          rise_q, late_q, fall_q;

    // Position of the two coming half-cycles within the period
    always_comb begin
        use_per  = (state_q == S_HOLD) ? per_new : per_q;
        base     = (state_q == S_HOLD) ? '0 : cnt_q;
        base_p1  = base + CW'(1);
        base_p2  = base + CW'(2);
        pos0     = base;
        pos1     = (base_p1 == use_per) ? '0 : base_p1;
        hi_len   = (use_per + CW'(1)) >> 1;
        cnt_adv  = (base_p2 >= use_per) ? (base_p2 - use_per) : base_p2;
        at_bound = (base == use_per - CW'(2));
    end

    // State register
    always_ff @(posedge src_clk) begin
        if (rst) state_q <= S_HOLD;
        else     state_q <= S_RUN;
    end

    // Rising-edge datapath
    always_ff @(posedge src_clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= per_new;
            rise_q <= 1'b0;
            late_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_HOLD: begin
                    per_q <= per_new;
                end
                S_RUN: begin
                    if (at_bound) per_q <= per_new;
                end
            endcase
            cnt_q  <= cnt_adv;
            rise_q <= (pos0 < hi_len) ^ fall_q;
            late_q <= (pos1 < hi_len);
        end
    end

    // Falling-edge register fixes the low-phase level
    always_ff @(negedge src_clk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= late_q ^ rise_q;
    end

    assign clk_o = rise_q ^ fall_q;

    AST_CNT_RANGE: assert property (@(posedge src_clk) disable iff (rst)
        (state_q == S_RUN) |-> (cnt_q < per_q)); // R1

    AST_PER_MIN: assert property (@(posedge src_clk) disable iff (rst)
        (state_q == S_RUN) |-> (per_q >= CW'(2))); // R4

    AST_LOAD_BOUNDARY: assert property (@(posedge src_clk) disable iff (rst)
        (state_q == S_RUN && $past(state_q) == S_RUN && per_q != $past(per_q))
        |-> ($past(cnt_q) == $past(per_q) - CW'(2))); // R8

    AST_RESET_CLEAR: assert property (@(posedge src_clk)
        $past(rst) |-> (!rise_q && !late_q && state_q == S_HOLD)); // R7

endmodule

// File: rtl/halfstep_clk_div.sv
module halfstep_clk_div #(
    parameter int unsigned NUM_OUT = 3,
    parameter int unsigned DIV_W   = hdiv_pkg::HD_DIV_W,
    localparam int unsigned CW     = DIV_W + 2
) (
    input  logic                          clk_ref,
    input  logic                          clk_syn,
    input  logic                          rst,
    input  logic                          use_osc,
    input  logic [NUM_OUT-1:0]            bypass,
    input  logic [NUM_OUT-1:0]            half_en,
    input  logic [NUM_OUT-1:0][DIV_W-1:0] div_code,
    output logic [NUM_OUT-1:0]            clk_out,
    output logic                          cfg_valid
);

    logic [NUM_OUT-1:0] req_bad;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        logic [CW-1:0] per_hc;
        logic          src_clk;

        hdiv_cfg #(.DIV_W(DIV_W)) u_cfg (
            .use_osc  (use_osc),
            .byp      (bypass[g]),
            .half_req (half_en[g]),
            .div_code (div_code[g]),
            .per_hc   (per_hc),
            .req_bad  (req_bad[g])
        );

        assign src_clk = bypass[g] ? clk_ref : clk_syn;

        hdiv_core #(.DIV_W(DIV_W)) u_core (
            .src_clk (src_clk),
            .rst     (rst),
            .per_new (per_hc),
            .clk_o   (clk_out[g])
        );
    end

    always_ff @(posedge clk_ref) begin
        if (rst) cfg_valid <= 1'b0;
        else     cfg_valid <= ~|req_bad;
    end

    AST_CFG_ERR: assert property (@(posedge clk_ref) disable iff (rst)
        (!$past(rst) && $past(|req_bad)) |-> !cfg_valid); // R4

    AST_CFG_OK: assert property (@(posedge clk_ref) disable iff (rst)
        (!$past(rst) && !$past(|req_bad)) |-> cfg_valid); // R5

endmodule

// File: tb/tb_halfstep_clk_div.sv
`timescale 1ps/1ps
module tb_halfstep_clk_div;

    localparam int NO   = 3;
    localparam int DW   = 5;
    localparam int RHP  = 2500;   // reference half period, 200 MHz
    localparam int SHP  = 1500;   // synthesized clock half period

    logic clk_ref = 1'b0, clk_syn = 1'b0, rst = 1'b1, use_osc = 1'b1;
    logic [NO-1:0]         bypass  = 3'b011;
    logic [NO-1:0]         half_en = '0;
    logic [NO-1:0][DW-1:0] div_code = '0;
    logic [NO-1:0]         clk_out;
    logic                  cfg_valid;

    int checks = 0, errors = 0;

    always #(RHP) clk_ref = ~clk_ref;
    always #(SHP) clk_syn = ~clk_syn;

    halfstep_clk_div #(.NUM_OUT(NO), .DIV_W(DW)) dut (
        .clk_ref(clk_ref), .clk_syn(clk_syn), .rst(rst), .use_osc(use_osc),
        .bypass(bypass), .half_en(half_en), .div_code(div_code),
        .clk_out(clk_out), .cfg_valid(cfg_valid)
    );

    task automatic check_int(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_rise(input int idx);
        case (idx)
            0: @(posedge clk_out[0]);
            1: @(posedge clk_out[1]);
            default: @(posedge clk_out[2]);
        endcase
    endtask

    task automatic wait_fall(input int idx);
        case (idx)
            0: @(negedge clk_out[0]);
            1: @(negedge clk_out[1]);
            default: @(negedge clk_out[2]);
        endcase
    endtask

    // Skip two rising edges so the new setting is in force, then measure
    task automatic measure(input int idx, input int hp, input int exp_per,
                           input string tag);
        longint t0, t1, t2;
        wait_rise(idx);
        wait_rise(idx);
        t0 = $time;
        wait_fall(idx);
        t1 = $time;
        wait_rise(idx);
        t2 = $time;
        check_int({tag, " period"}, (t2 - t0) / hp, exp_per);
        check_int({tag, " high"}, (t1 - t0) / hp, (exp_per + 1) / 2); // R3
    endtask

    initial begin
        #(longint'(RHP) * 2 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint t0, t1, t2;
        repeat (10) @(posedge clk_ref);
        @(negedge clk_ref);
        // R7: all low in reset
        check_int("R7 outputs in reset", clk_out, 0);
        check_int("R7 cfg_valid in reset", cfg_valid, 0);
        rst = 1'b0;
        @(posedge clk_ref);
        #100;
        check_int("R7 first rise after reset", clk_out[1:0], 2'b11);
        @(negedge clk_ref);
        check_int("R5 cfg_valid clean", cfg_valid, 1);

        // R1 / R2 / R3 sweep: out0 integer, out1 half-step
        for (int k = 0; k < 32; k++) begin
            @(negedge clk_ref);
            div_code[0] = DW'(k);
            div_code[1] = DW'(k);
            half_en[1]  = 1'b1;
            @(negedge clk_ref);
            @(negedge clk_ref);
            if (k == 0) check_int("R4 cfg_valid half N=1", cfg_valid, 0);
            else        check_int("R5 cfg_valid half ok", cfg_valid, 1);
            measure(0, RHP, 2 * (k + 1), "R1 integer");
            if (k == 0) measure(1, RHP, 2, "R4 half N=1 ignored");
            else        measure(1, RHP, k + 1, "R2 half-step");
        end

        // R6: non-bypass output divides clk_syn; half request ignored
        for (int k = 0; k < 6; k++) begin
            @(negedge clk_ref);
            div_code[2] = DW'(k * 5);
            half_en[2]  = k[0];
            @(negedge clk_ref);
            @(negedge clk_ref);
            check_int("R4 cfg_valid half on synth path", cfg_valid, k[0] ? 0 : 1);
            measure(2, SHP, 2 * (k * 5 + 1), "R6 synth path");
        end
        @(negedge clk_ref);
        half_en[2] = 1'b0;

        // R4: half-step with use_osc=0 falls back to integer
        @(negedge clk_ref);
        use_osc     = 1'b0;
        div_code[1] = 5'd4;
        half_en[1]  = 1'b1;
        @(negedge clk_ref);
        @(negedge clk_ref);
        check_int("R4 cfg_valid no osc", cfg_valid, 0);
        measure(1, RHP, 10, "R4 no-osc integer");
        @(negedge clk_ref);
        use_osc = 1'b1;
        @(negedge clk_ref);
        @(negedge clk_ref);
        check_int("R5 cfg_valid restored", cfg_valid, 1);
        measure(1, RHP, 5, "R2 half N=5");

        // R9: changing out0 leaves out1 unchanged
        @(negedge clk_ref);
        div_code[0] = 5'd9;
        measure(1, RHP, 5, "R9 out1 independent");
        measure(0, RHP, 20, "R9 out0 new code");

        // R8: mid-period change completes the old period
        @(negedge clk_ref);
        div_code[0] = 5'd31;
        measure(0, RHP, 64, "R8 long period");
        @(posedge clk_out[0]);
        t0 = $time;
        repeat (10) @(negedge clk_ref);
        div_code[0] = 5'd1;
        @(posedge clk_out[0]);
        t1 = $time;
        @(posedge clk_out[0]);
        t2 = $time;
        check_int("R8 old period kept", (t1 - t0) / RHP, 64);
        check_int("R8 new period after boundary", (t2 - t1) / RHP, 4);

        // R7: reset again drives everything low
        @(negedge clk_ref);
        rst = 1'b1;
        repeat (6) @(negedge clk_ref);
        check_int("R7 outputs in second reset", clk_out, 0);
        check_int("R7 cfg_valid in second reset", cfg_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule